// File: doc/BRIEF.md
# Bus Clock Master Fallback Controller

This controller sits on a board that masters one of two redundant backplane bus clocks (bus A and bus B). Each cycle it decides which timing source the board's phase-locked loop follows: the board's primary timing reference, its fallback timing reference, one of the two bus clocks, or the local free-running oscillator. It also decides whether the board drives its assigned bus clock. Loss detectors outside the block supply one "good" flag per source. The controller filters each flag against glitches and walks an escalation chain that depends on the board's role.

A board in the primary role drives its bus clock while it has a usable reference. When both of its references are gone, it hands mastership over and follows the other bus clock. A board in the secondary role follows the primary master's bus clock as a slave and always drives the other bus clock. When the primary master's clock is lost, it falls back to its own fallback reference, and to the oscillator after that. Neither role ever climbs back to its starting source by itself. A software re-arm pulse restores the home state.

Top module: `refsel_fallback_ctrl`

## Requirements
- R1: After synchronous reset the block is in its home state with every filtered flag taken as good. In the primary role this is state code 0, locked to the primary reference and driving its own bus. In the secondary role this is state code 4, locked to the peer bus and driving its own bus.
- R2: A change of a source's good flag affects the block only after the raw flag has held the new value on HOLD_CYCLES consecutive clock edges. Shorter pulses are ignored.
- R3: Primary role: loss of the primary reference moves the lock to the fallback reference (code 1), and the own bus keeps being driven.
- R4: Primary role, code 1: loss of the fallback reference stops the drive of the own bus and moves the lock to the peer bus clock (code 2).
- R5: Primary role, code 2: loss of the peer bus moves the lock to the oscillator (code 3). Return of the peer bus moves it back to the peer bus (code 2). Neither bus is driven in codes 2 and 3.
- R6: Secondary role, code 4: loss of the peer bus (the primary master's bus) moves the lock to the fallback reference (code 5), and the own bus stays driven.
- R7: Secondary role, code 5: loss of the fallback reference moves the lock to the oscillator (code 6) with the own bus still driven. Recovery of the fallback reference moves the lock back to it (code 5).
- R8: The block never re-enters its home state without reset or a re-arm pulse, even when the primary reference or the peer bus recovers. A re-arm pulse returns it to the home state on the next edge.
- R9: With fallback_en low, the state does not change (re-arm and reset excepted).
- R10: lock_sel is one-hot, with bit 0 = primary reference, 1 = fallback reference, 2 = bus A, 3 = bus B, 4 = oscillator. drive_a and drive_b are never both high.
- R11: The own bus is bus B when bus_b_sel=1 in the primary role, or when bus_b_sel=0 in the secondary role; otherwise it is bus A. The peer bus is the other one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_secondary | input | 1 | 0 = primary master role, 1 = secondary master role (static) |
| bus_b_sel | input | 1 | Bus that the primary master drives: 0 = A, 1 = B (static) |
| fallback_en | input | 1 | Enables all fallback transitions |
| rearm | input | 1 | Software pulse that returns the block to its home state |
| pri_ref_ok | input | 1 | Raw good flag of the primary timing reference |
| fbk_ref_ok | input | 1 | Raw good flag of the fallback timing reference |
| bus_a_ok | input | 1 | Raw good flag of bus clock A |
| bus_b_ok | input | 1 | Raw good flag of bus clock B |
| lock_sel | output | 5 | One-hot timing source select |
| drive_a | output | 1 | Drive enable for bus clock A |
| drive_b | output | 1 | Drive enable for bus clock B |
| state_code | output | 3 | Current state code (0 to 6) |

## Verification
The assertions assume that role_secondary and bus_b_sel change only while reset is asserted. The revert and hold checks rely on this, because a role change would make the home state unreachable by legal paths. The stimulus reconfigures these two inputs only inside a reset pulse. It changes the good flags and the re-arm pulse at falling edges, which keeps the raw inputs stable around each sampling edge. The glitch pulses are deliberately shorter than the hold window, so that the filters show they reject them.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [2:0] {
        ST_P_LOCAL   = 3'd0,
        ST_P_BACKUP  = 3'd1,
        ST_P_PEER    = 3'd2,
        ST_P_FREERUN = 3'd3,
        ST_S_FOLLOW  = 3'd4,
        ST_S_BACKUP  = 3'd5,
        ST_S_FREERUN = 3'd6
    } fb_state_e;

    localparam int NUM_FLAGS = 4;
    localparam int IDX_PRI   = 0;
    localparam int IDX_FBK   = 1;
    localparam int IDX_BUSA  = 2;
    localparam int IDX_BUSB  = 3;

    localparam int SEL_W     = 5;
    localparam int SEL_PRI   = 0;
    localparam int SEL_FBK   = 1;
    localparam int SEL_BUSA  = 2;
    localparam int SEL_BUSB  = 3;
    localparam int SEL_OSC   = 4;

    function automatic fb_state_e home_state(input logic secondary);
        return secondary ? ST_S_FOLLOW : ST_P_LOCAL;
    endfunction

    function automatic logic in_primary_chain(input fb_state_e s);
        return (s == ST_P_LOCAL) || (s == ST_P_BACKUP) ||
               (s == ST_P_PEER)  || (s == ST_P_FREERUN);
    endfunction

    function automatic logic in_secondary_chain(input fb_state_e s);
        return (s == ST_S_FOLLOW) || (s == ST_S_BACKUP) || (s == ST_S_FREERUN);
    endfunction

endpackage

// File: rtl/refsel_deglitch.sv
module refsel_deglitch #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            filt_q <= 1'b1;
        end else if (raw == filt_q) begin
            run_q  <= '0;
        end else if (run_q == LAST) begin
            run_q  <= '0;
            filt_q <= raw;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign filt = filt_q;

endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 secondary,
    input  logic                 own_is_b,
    input  logic                 fallback_en,
    input  logic                 rearm,
    input  logic [NUM_FLAGS-1:0] health,
    output fb_state_e            state_q
);
    fb_state_e state_d;
    logic      peer_ok;
    logic      pri_ok;
    logic      fbk_ok;

    assign peer_ok = own_is_b ? health[IDX_BUSA] : health[IDX_BUSB];
    assign pri_ok  = health[IDX_PRI];
    assign fbk_ok  = health[IDX_FBK];

    always_comb begin
        state_d = state_q;
        if (rearm) begin
            state_d = home_state(secondary);
        end else if (fallback_en) begin
            if (!secondary) begin
                unique case (state_q)
                    ST_P_LOCAL:   if (!pri_ok)  state_d = ST_P_BACKUP;
                    ST_P_BACKUP:  if (!fbk_ok)  state_d = ST_P_PEER;
                    ST_P_PEER:    if (!peer_ok) state_d = ST_P_FREERUN;
                    ST_P_FREERUN: if (peer_ok)  state_d = ST_P_PEER;
                    default:                    state_d = ST_P_LOCAL;
                endcase
            end else begin
                unique case (state_q)
                    ST_S_FOLLOW:  if (!peer_ok) state_d = ST_S_BACKUP;
                    ST_S_BACKUP:  if (!fbk_ok)  state_d = ST_S_FREERUN;
                    ST_S_FREERUN: if (fbk_ok)   state_d = ST_S_BACKUP;
                    default:                    state_d = ST_S_FOLLOW;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= home_state(secondary);
        else     state_q <= state_d;
    end

    // R8
    prim_no_revert_chk: assert property (@(posedge clk) disable iff (rst)
        (!secondary && in_primary_chain(state_q) && state_q != ST_P_LOCAL && !rearm)
        |=> (state_q != ST_P_LOCAL));

    // R8
    sec_no_revert_chk: assert property (@(posedge clk) disable iff (rst)
        (secondary && in_secondary_chain(state_q) && state_q != ST_S_FOLLOW && !rearm)
        |=> (state_q != ST_S_FOLLOW));

    // R9
    fallback_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fallback_en && !rearm && (secondary ? in_secondary_chain(state_q)
                                              : in_primary_chain(state_q)))
        |=> $stable(state_q));

endmodule

// File: rtl/refsel_outmap.sv
module refsel_outmap
    import refsel_pkg::*;
(
    input  fb_state_e          state,
    input  logic               own_is_b,
    output logic [SEL_W-1:0]   lock_sel,
    output logic               drive_a,
    output logic               drive_b,
    output logic [2:0]         state_code
);
    logic own_active;
    int   peer_bit;

    assign peer_bit = own_is_b ? SEL_BUSA : SEL_BUSB;

    always_comb begin
        lock_sel   = '0;
        own_active = 1'b0;
        unique case (state)
            ST_P_LOCAL:   begin lock_sel[SEL_PRI]  = 1'b1; own_active = 1'b1; end
            ST_P_BACKUP:  begin lock_sel[SEL_FBK]  = 1'b1; own_active = 1'b1; end
            ST_P_PEER:    begin lock_sel[peer_bit] = 1'b1; end
            ST_P_FREERUN: begin lock_sel[SEL_OSC]  = 1'b1; end
            ST_S_FOLLOW:  begin lock_sel[peer_bit] = 1'b1; own_active = 1'b1; end
            ST_S_BACKUP:  begin lock_sel[SEL_FBK]  = 1'b1; own_active = 1'b1; end
            default:      begin lock_sel[SEL_OSC]  = 1'b1; own_active = 1'b1; end
        endcase
    end

    assign drive_a    = own_active && !own_is_b;
    assign drive_b    = own_active &&  own_is_b;
    assign state_code = state;

endmodule

// File: rtl/refsel_fallback_ctrl.sv
module refsel_fallback_ctrl
    import refsel_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       role_secondary,
    input  logic       bus_b_sel,
    input  logic       fallback_en,
    input  logic       rearm,
    input  logic       pri_ref_ok,
    input  logic       fbk_ref_ok,
    input  logic       bus_a_ok,
    input  logic       bus_b_ok,
    output logic [4:0] lock_sel,
    output logic       drive_a,
    output logic       drive_b,
    output logic [2:0] state_code
);
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] health;
    logic                 own_is_b;
    fb_state_e            state_q;

    assign raw_flags[IDX_PRI]  = pri_ref_ok;
    assign raw_flags[IDX_FBK]  = fbk_ref_ok;
    assign raw_flags[IDX_BUSA] = bus_a_ok;
    assign raw_flags[IDX_BUSB] = bus_b_ok;

    // the secondary master drives the bus the primary master leaves free
    assign own_is_b = role_secondary ? !bus_b_sel : bus_b_sel;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_filter
        refsel_deglitch #(.HOLD_CYCLES(HOLD_CYCLES)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_flags[i]),
            .filt (health[i])
        );
    end

    refsel_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .secondary   (role_secondary),
        .own_is_b    (own_is_b),
        .fallback_en (fallback_en),
        .rearm       (rearm),
        .health      (health),
        .state_q     (state_q)
    );

    refsel_outmap u_map (
        .state      (state_q),
        .own_is_b   (own_is_b),
        .lock_sel   (lock_sel),
        .drive_a    (drive_a),
        .drive_b    (drive_b),
        .state_code (state_code)
    );

    // R10
    drive_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(drive_a && drive_b));

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(lock_sel) == 1);

    // R4
    handover_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!role_secondary && (lock_sel[SEL_BUSA] || lock_sel[SEL_BUSB] || lock_sel[SEL_OSC]))
        |-> (!drive_a && !drive_b));

    // R6
    secondary_drives_chk: assert property (@(posedge clk) disable iff (rst)
        role_secondary |-> (drive_a || drive_b));

endmodule

// File: tb/refsel_fallback_ctrl_test.sv
module refsel_fallback_ctrl_test;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic role_secondary = 1'b0, bus_b_sel = 1'b0, fallback_en = 1'b1, rearm = 1'b0;
    logic pri_ref_ok = 1'b1, fbk_ref_ok = 1'b1, bus_a_ok = 1'b1, bus_b_ok = 1'b1;
    logic [4:0] lock_sel;
    logic drive_a, drive_b;
    logic [2:0] state_code;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    always #10 clk = ~clk;

    refsel_fallback_ctrl #(.HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst(rst), .role_secondary(role_secondary), .bus_b_sel(bus_b_sel),
        .fallback_en(fallback_en), .rearm(rearm), .pri_ref_ok(pri_ref_ok),
        .fbk_ref_ok(fbk_ref_ok), .bus_a_ok(bus_a_ok), .bus_b_ok(bus_b_ok),
        .lock_sel(lock_sel), .drive_a(drive_a), .drive_b(drive_b), .state_code(state_code)
    );

    // behavioural reference: per-flag run counters and an integer mode
    int  m_run  [4];
    bit  m_good [4];
    int  m_mode = 0;

    function automatic bit raw_of(int i);
        case (i)
            0: return pri_ref_ok;
            1: return fbk_ref_ok;
            2: return bus_a_ok;
            default: return bus_b_ok;
        endcase
    endfunction

    function automatic bit own_b();
        return role_secondary ? !bus_b_sel : bus_b_sel;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_run[i] = 0; m_good[i] = 1'b1; end
            m_mode = role_secondary ? 4 : 0;
        end else begin
            bit peer_good;
            peer_good = own_b() ? m_good[2] : m_good[3];
            if (rearm) m_mode = role_secondary ? 4 : 0;
            else if (fallback_en) begin
                case (m_mode)
                    0: if (!m_good[0]) m_mode = 1;
                    1: if (!m_good[1]) m_mode = 2;
                    2: if (!peer_good) m_mode = 3;
                    3: if (peer_good)  m_mode = 2;
                    4: if (!peer_good) m_mode = 5;
                    5: if (!m_good[1]) m_mode = 6;
                    6: if (m_good[1])  m_mode = 5;
                    default: ;
                endcase
            end
            for (int i = 0; i < 4; i++) begin
                if (raw_of(i) == m_good[i]) m_run[i] = 0;
                else if (m_run[i] + 1 >= HOLD) begin m_run[i] = 0; m_good[i] = raw_of(i); end
                else m_run[i] = m_run[i] + 1;
            end
        end
    end

    always @(posedge clk) begin
        #5;
        if (!rst && !finished) begin
            logic [4:0] exp_sel;
            bit exp_drv, exp_a, exp_b;
            exp_sel = '0;
            exp_drv = 1'b0;
            case (m_mode)
                0: begin exp_sel[0] = 1'b1; exp_drv = 1'b1; end
                1: begin exp_sel[1] = 1'b1; exp_drv = 1'b1; end
                2: exp_sel[own_b() ? 2 : 3] = 1'b1;
                3: exp_sel[4] = 1'b1;
                4: begin exp_sel[own_b() ? 2 : 3] = 1'b1; exp_drv = 1'b1; end
                5: begin exp_sel[1] = 1'b1; exp_drv = 1'b1; end
                default: begin exp_sel[4] = 1'b1; exp_drv = 1'b1; end
            endcase
            exp_a = exp_drv && !own_b();
            exp_b = exp_drv && own_b();
            checks++;
            if (lock_sel !== exp_sel || drive_a !== exp_a || drive_b !== exp_b
                || state_code !== 3'(m_mode)) begin
                errors++;
                $display("FAIL %s: sel=%b drv_a=%b drv_b=%b code=%0d, expected sel=%b drv_a=%b drv_b=%b code=%0d",
                         cur_req, lock_sel, drive_a, drive_b, state_code,
                         exp_sel, exp_a, exp_b, m_mode);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(bit sec, bit bsel);
        @(negedge clk);
        rst = 1'b1; role_secondary = sec; bus_b_sel = bsel; rearm = 1'b0;
        fallback_en = 1'b1;
        pri_ref_ok = 1'b1; fbk_ref_ok = 1'b1; bus_a_ok = 1'b1; bus_b_ok = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
    endtask

    task automatic pulse_rearm();
        rearm = 1'b1; wait_cyc(1); rearm = 1'b0;
    endtask

    initial begin
        // primary role, drives bus A (R1, R11)
        cur_req = "R1"; do_reset(1'b0, 1'b0); wait_cyc(4);
        // glitches shorter than the hold window (R2)
        cur_req = "R2";
        pri_ref_ok = 1'b0; wait_cyc(HOLD - 1); pri_ref_ok = 1'b1; wait_cyc(6);
        bus_b_ok = 1'b0; wait_cyc(2); bus_b_ok = 1'b1; wait_cyc(6);
        // R3
        cur_req = "R3"; pri_ref_ok = 1'b0; wait_cyc(HOLD + 3);
        // recovery of the primary reference must not revert (R8)
        cur_req = "R8"; pri_ref_ok = 1'b1; wait_cyc(HOLD + 4);
        // R4
        cur_req = "R4"; fbk_ref_ok = 1'b0; wait_cyc(HOLD + 3);
        // R5: peer bus B lost then back
        cur_req = "R5"; bus_b_ok = 1'b0; wait_cyc(HOLD + 3);
        bus_b_ok = 1'b1; wait_cyc(HOLD + 3);
        fbk_ref_ok = 1'b1; wait_cyc(HOLD + 3);
        // R8: re-arm
        cur_req = "R8"; pulse_rearm(); wait_cyc(3);
        // R9: fallback disabled
        cur_req = "R9"; fallback_en = 1'b0; pri_ref_ok = 1'b0; fbk_ref_ok = 1'b0;
        wait_cyc(HOLD + 5);
        fallback_en = 1'b1; wait_cyc(HOLD + 3);
        // both references down at once: two steps (R4)
        cur_req = "R4"; wait_cyc(3);

        // primary role, drives bus B (R11)
        cur_req = "R11"; do_reset(1'b0, 1'b1); wait_cyc(3);
        pri_ref_ok = 1'b0; fbk_ref_ok = 1'b0; wait_cyc(HOLD + 4);
        bus_a_ok = 1'b0; wait_cyc(HOLD + 3);

        // secondary role, primary master on B, own bus A (R1, R6, R7)
        cur_req = "R1"; do_reset(1'b1, 1'b1); wait_cyc(3);
        cur_req = "R6"; bus_b_ok = 1'b0; wait_cyc(HOLD + 3);
        cur_req = "R7"; fbk_ref_ok = 1'b0; wait_cyc(HOLD + 3);
        fbk_ref_ok = 1'b1; wait_cyc(HOLD + 3);
        cur_req = "R8"; bus_b_ok = 1'b1; wait_cyc(HOLD + 4);
        pulse_rearm(); wait_cyc(3);
        cur_req = "R2"; bus_b_ok = 1'b0; wait_cyc(HOLD - 1); bus_b_ok = 1'b1; wait_cyc(5);

        // secondary role, primary master on A, own bus B (R11)
        cur_req = "R11"; do_reset(1'b1, 1'b0); wait_cyc(3);
        bus_a_ok = 1'b0; wait_cyc(HOLD + 3);
        cur_req = "R9"; fallback_en = 1'b0; fbk_ref_ok = 1'b0; wait_cyc(HOLD + 4);
        cur_req = "R7"; fallback_en = 1'b1; wait_cyc(4);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule